// File: doc/BRIEF.md
# PCI Configuration and I/O Access Port

This block sits between a CPU register window and a downstream PCI transaction engine. It holds a 32-bit configuration-address register. Accesses to the configuration-data window are turned into PCI configuration cycles, and accesses to the I/O-data window are turned into PCI I/O cycles. The downstream address for both comes from the stored register with its two low bits cleared, combined with the byte offset of the access inside the data window.

Both sides use valid/ready handshakes. The CPU raises `cpu_req_valid` and holds every request field stable. The port answers with a one-cycle `cpu_req_ready` pulse, and `cpu_rdata` and `cpu_err` are valid in that cycle. For data accesses the pulse comes only after the downstream response has been taken, so a slow PCI target stalls the CPU. The downstream request keeps all of its fields stable while `dn_req_valid` is high and `dn_req_ready` is low. The port takes a response whenever `dn_rsp_ready` is high. Accesses the port judges illegal complete with an error and never reach the downstream side.

Window layout: offset 0x0 is the address register, 0x4 to 0x7 is configuration data, and 0x8 to 0xB is I/O data. Sizes are byte counts.

Top module: `pcia_port`

## Requirements
- R1: A 4-byte write at offset 0x0 stores all 32 bits, and a 4-byte read there returns them unchanged, bits 1:0 included. After reset the register reads 0.
- R2: An access at offset 0x0 with any size other than 4 completes with `cpu_err`=1, leaves the register unchanged and issues no downstream request.
- R3: An access at offset 0x4+k issues one request with `dn_space`=0 and `dn_addr` = (register with bits 1:0 cleared) OR k.
- R4: An access at offset 0x8+k issues one request with `dn_space`=1. Its `dn_addr` is (register with bits 1:0 cleared) + k, truncated to IO_AW (16) bits, with the upper bits zero.
- R5: A data access is legal only if the size is 1, 2 or 4 and the access is naturally aligned. At k=0 any legal size is allowed, at k=2 only sizes 1 and 2, and at k=1 or k=3 only size 1. An illegal access gives `cpu_err`=1, `cpu_rdata`=0 and no downstream request.
- R6: Offsets 0x1 to 0x3 and 0xC to 0xF give `cpu_err`=1 and no downstream request.
- R7: I/O data is big-endian. For size n, `dn_wdata` byte lane i (bits 8i+7:8i) carries the write value's byte n-1-i, where byte 0 is the least significant. On a read, response lane i becomes byte n-1-i of the right-justified `cpu_rdata`. Unused lanes are 0.
- R8: Configuration data is little-endian. Lane i carries value byte i for i<n, other lanes are 0, and reads are right-justified the same way.
- R9: For a data access, `cpu_req_ready` rises only after the downstream response handshake, exactly one downstream request is issued, and `cpu_req_ready` is a single-cycle pulse.
- R10: While `dn_req_valid`=1 and `dn_req_ready`=0, all `dn_*` request fields hold their values.
- R11: After reset `cpu_req_ready`=0 and `dn_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access request, held until ready |
| cpu_req_ready | output | 1 | Completion pulse; response valid this cycle |
| cpu_offset | input | 4 | Byte offset in the register window |
| cpu_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| cpu_write | input | 1 | 1 = write |
| cpu_wdata | input | 32 | Right-justified write value |
| cpu_rdata | output | 32 | Right-justified read value |
| cpu_err | output | 1 | Access rejected |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_space | output | 1 | 0 = configuration, 1 = I/O |
| dn_addr | output | 32 | Cycle address |
| dn_size | output | 3 | Byte count |
| dn_write | output | 1 | 1 = write cycle |
| dn_wdata | output | 32 | Lane-ordered write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Port accepts response |
| dn_rsp_rdata | input | 32 | Lane-ordered read data |

## Verification
The hardest condition to reach from the ports is the 16-bit wrap of the I/O address. It appears only when the stored address already has high bits set, so that bits above IO_AW must be dropped. It also needs an odd byte offset and a size-1 access, so that the sum lands on the last address before the wrap. The stimulus loads such an address directly and then lets random accesses reuse random register contents. The downstream responder inserts random delays on both request acceptance and response. This exercises the stall path and the rule that request fields stay stable while waiting.

// File: rtl/pcia_pkg.sv
package pcia_pkg;
  typedef enum logic [1:0] {
    TGT_ADDR = 2'd0,
    TGT_CFG  = 2'd1,
    TGT_IO   = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } state_e;
endpackage

// File: rtl/pcia_decode.sv
module pcia_decode
  import pcia_pkg::*;
#(
  parameter int OFS_W    = 4,
  parameter int SZW      = 3,
  parameter int ADDR_OFS = 0,
  parameter int CFG_OFS  = 4,
  parameter int IO_OFS   = 8
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [SZW-1:0]   size,
  output tgt_e             tgt,
  output logic             err,
  output logic [1:0]       lane
);
  localparam int WW = OFS_W - 2;
  localparam logic [WW-1:0] W_ADDR = WW'(ADDR_OFS / 4);
  localparam logic [WW-1:0] W_CFG  = WW'(CFG_OFS / 4);
  localparam logic [WW-1:0] W_IO   = WW'(IO_OFS / 4);

  logic [WW-1:0] word;
  logic          size_ok;
  logic          aligned;

  assign word = offset[OFS_W-1:2];
  assign lane = offset[1:0];

  always_comb begin
    size_ok = (size == SZW'(1)) || (size == SZW'(2)) || (size == SZW'(4));
    case (size)
      SZW'(4): aligned = (lane == 2'd0);
      SZW'(2): aligned = (lane[0] == 1'b0);
      default: aligned = 1'b1;
    endcase
  end

  always_comb begin
    tgt = TGT_NONE;
    err = 1'b1;
    if (word == W_ADDR) begin
      tgt = TGT_ADDR;
      err = !((lane == 2'd0) && (size == SZW'(4)));
    end else if (word == W_CFG) begin
      tgt = TGT_CFG;
      err = !(size_ok && aligned);
    end else if (word == W_IO) begin
      tgt = TGT_IO;
      err = !(size_ok && aligned);
    end
  end
endmodule

// File: rtl/pcia_lane_order.sv
module pcia_lane_order #(
  parameter int DW  = 32,
  parameter int SZW = 3
) (
  input  logic [DW-1:0]  din,
  input  logic [SZW-1:0] nbytes,
  input  logic           swap,
  output logic [DW-1:0]  dout
);
  localparam int LANES = DW / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SZW-1:0] src;
    always_comb begin
      src = swap ? (nbytes - SZW'(1) - SZW'(i)) : SZW'(i);
      if (SZW'(i) < nbytes)
        dout[8*i +: 8] = din[8*src +: 8];
      else
        dout[8*i +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/pcia_port.sv
module pcia_port
  import pcia_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IO_AW    = 16,
  parameter int DW       = 32,
  parameter int OFS_W    = 4,
  parameter int CFG_OFS  = 4,
  parameter int IO_OFS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  output logic             cpu_req_ready,
  input  logic [OFS_W-1:0] cpu_offset,
  input  logic [2:0]       cpu_size,
  input  logic             cpu_write,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_err,
  output logic             dn_req_valid,
  input  logic             dn_req_ready,
  output logic             dn_space,
  output logic [AW-1:0]    dn_addr,
  output logic [2:0]       dn_size,
  output logic             dn_write,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rsp_valid,
  output logic             dn_rsp_ready,
  input  logic [DW-1:0]    dn_rsp_rdata
);
  localparam int SZW = 3;

  state_e         st_q;
  logic [AW-1:0]  cfg_addr_q;
  tgt_e           tgt_q;
  logic           err_q;
  logic [1:0]     lane_q;
  logic [SZW-1:0] size_q;
  logic           write_q;
  logic [DW-1:0]  wval_q;
  logic [DW-1:0]  rdata_q;

  tgt_e           dec_tgt;
  logic           dec_err;
  logic [1:0]     dec_lane;

  pcia_decode #(
    .OFS_W(OFS_W), .SZW(SZW), .ADDR_OFS(0), .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
  ) u_dec (
    .offset(cpu_offset), .size(cpu_size),
    .tgt(dec_tgt), .err(dec_err), .lane(dec_lane)
  );

  logic          is_io;
  logic [DW-1:0] wlanes;
  logic [DW-1:0] rval;

  assign is_io = (tgt_q == TGT_IO);

  pcia_lane_order #(.DW(DW), .SZW(SZW)) u_wr_order (
    .din(wval_q), .nbytes(size_q), .swap(is_io), .dout(wlanes)
  );

  pcia_lane_order #(.DW(DW), .SZW(SZW)) u_rd_order (
    .din(dn_rsp_rdata), .nbytes(size_q), .swap(is_io), .dout(rval)
  );

  logic [AW-1:0] base_addr;
  logic [AW-1:0] io_sum;
  assign base_addr = {cfg_addr_q[AW-1:2], 2'b00};
  assign io_sum    = base_addr + AW'(lane_q);

  always_comb begin
    if (is_io)
      dn_addr = {{(AW-IO_AW){1'b0}}, io_sum[IO_AW-1:0]};
    else
      dn_addr = {cfg_addr_q[AW-1:2], lane_q};
  end

  assign dn_req_valid  = (st_q == S_ISSUE);
  assign dn_space      = is_io;
  assign dn_size       = size_q;
  assign dn_write      = write_q;
  assign dn_wdata      = write_q ? wlanes : '0;
  assign dn_rsp_ready  = (st_q == S_WAIT);
  assign cpu_req_ready = (st_q == S_DONE);
  assign cpu_rdata     = rdata_q;
  assign cpu_err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cfg_addr_q <= '0;
      tgt_q      <= TGT_NONE;
      err_q      <= 1'b0;
      lane_q     <= 2'd0;
      size_q     <= '0;
      write_q    <= 1'b0;
      wval_q     <= '0;
      rdata_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (cpu_req_valid) begin
            tgt_q   <= dec_tgt;
            err_q   <= dec_err;
            lane_q  <= dec_lane;
            size_q  <= cpu_size;
            write_q <= cpu_write;
            wval_q  <= cpu_wdata;
            rdata_q <= '0;
            if (dec_err) begin
              st_q <= S_DONE;
            end else if (dec_tgt == TGT_ADDR) begin
              if (cpu_write) cfg_addr_q <= cpu_wdata;
              else           rdata_q    <= cfg_addr_q;
              st_q <= S_DONE;
            end else begin
              st_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: if (dn_req_ready) st_q <= S_WAIT;
        S_WAIT: begin
          if (dn_rsp_valid) begin
            if (!write_q) rdata_q <= rval;
            st_q <= S_DONE;
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcia_port_chk.sv
module pcia_port_chk #(
  parameter int AW    = 32,
  parameter int IO_AW = 16,
  parameter int DW    = 32,
  parameter int OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic [OFS_W-1:0] cpu_offset,
  input logic [2:0]       cpu_size,
  input logic             dn_req_valid,
  input logic             dn_req_ready,
  input logic             dn_space,
  input logic [AW-1:0]    dn_addr,
  input logic [2:0]       dn_size,
  input logic             dn_write,
  input logic [DW-1:0]    dn_wdata,
  input logic             dn_rsp_valid,
  input logic             dn_rsp_ready
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_addr) &&
      $stable(dn_space) && $stable(dn_size) && $stable(dn_write) && $stable(dn_wdata)));

  p_lane_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> (dn_addr[1:0] == cpu_offset[1:0]));

  p_io_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && dn_space) |-> (dn_addr[AW-1:IO_AW] == '0));

  p_odd_byte_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !(cpu_offset[0] && (cpu_size != 3'd1)));

  p_rsp_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rsp_valid && dn_rsp_ready) |=> cpu_req_ready);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |=> !cpu_req_ready);

  p_no_issue_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> cpu_req_valid);
endmodule

bind pcia_port pcia_port_chk #(.AW(AW), .IO_AW(IO_AW), .DW(DW), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_offset(cpu_offset), .cpu_size(cpu_size), .dn_req_valid(dn_req_valid),
  .dn_req_ready(dn_req_ready), .dn_space(dn_space), .dn_addr(dn_addr), .dn_size(dn_size),
  .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
  .dn_rsp_ready(dn_rsp_ready)
);

// File: tb/sim_pcia_port.sv
module sim_pcia_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [3:0]  cpu_offset = '0;
  logic [2:0]  cpu_size = '0;
  logic        cpu_write = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_err;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic        dn_space;
  logic [31:0] dn_addr;
  logic [2:0]  dn_size;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic        dn_rsp_ready;
  logic [31:0] dn_rsp_rdata = '0;

  always #5 clk = ~clk;

  pcia_port u0 (.*);

  int n_checks = 0;
  int n_fail = 0;
  int req_count = 0;
  int rsp_count = 0;
  logic        seen_space, seen_write;
  logic [31:0] seen_addr, seen_wdata;
  logic [2:0]  seen_size;
  logic [31:0] rsp_word;
  logic [31:0] model_reg = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] order(logic [31:0] v, int n, bit rev);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = rev ? v[8*(n-1-i) +: 8] : v[8*i +: 8];
    return r;
  endfunction

  function automatic bit legal(logic [3:0] ofs, logic [2:0] sz);
    int k = ofs[1:0];
    if (ofs[3:2] == 2'd0) return (k == 0) && (sz == 3'd4);
    if (ofs[3:2] == 2'd3) return 1'b0;
    if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) return 1'b0;
    if (sz == 3'd4) return k == 0;
    if (sz == 3'd2) return (k == 0) || (k == 2);
    return 1'b1;
  endfunction

  // downstream responder with random stalls
  initial begin
    forever begin
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      if (rst_n && dn_req_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        dn_req_ready = 1'b1;
        seen_space = dn_space; seen_addr = dn_addr; seen_size = dn_size;
        seen_write = dn_write; seen_wdata = dn_wdata;
        @(negedge clk);
        dn_req_ready = 1'b0;
        req_count++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        rsp_word = $urandom;
        dn_rsp_rdata = rsp_word;
        dn_rsp_valid = 1'b1;
        rsp_count++;
      end
    end
  end

  task automatic access(logic [3:0] ofs, logic [2:0] sz, logic wr, logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int rq, output int rs);
    int rq0, rs0;
    @(negedge clk);
    rq0 = req_count; rs0 = rsp_count;
    cpu_offset = ofs; cpu_size = sz; cpu_write = wr; cpu_wdata = wd; cpu_req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (cpu_req_ready) break;
    end
    rd = cpu_rdata; er = cpu_err; rq = req_count - rq0; rs = rsp_count - rs0;
    @(posedge clk);
    #1 cpu_req_valid = 1'b0;
  endtask

  task automatic run_and_check(logic [3:0] ofs, logic [2:0] sz, logic wr, logic [31:0] wd);
    logic [31:0] rd, exp_addr, base;
    logic er;
    int rq, rs, k, n;
    bit ok;
    ok = legal(ofs, sz);
    k = ofs[1:0];
    n = sz;
    base = {model_reg[31:2], 2'b00};
    access(ofs, sz, wr, wd, rd, er, rq, rs);
    check(ofs[3:2] == 0 ? "R2 err flag" : (ofs[3:2] == 3 ? "R6 err flag" : "R5 err flag"),
          32'(er), 32'(!ok));
    if (!ok) begin
      check("R5 no downstream on error", 32'(rq), 0);
      check("R5 rdata zero on error", rd, 0);
    end else if (ofs[3:2] == 2'd0) begin
      check("R2 no downstream for addr reg", 32'(rq), 0);
      if (wr) model_reg = wd;
      else check("R1 addr readback", rd, model_reg);
    end else begin
      check("R9 one request and response", 32'(rq * 10 + rs), 11);
      check("R9 request size", 32'(seen_size), 32'(sz));
      check("R9 request dir", 32'(seen_write), 32'(wr));
      if (ofs[3:2] == 2'd1) begin
        exp_addr = base | 32'(k);
        check("R3 config space", 32'(seen_space), 0);
        check("R3 config addr", seen_addr, exp_addr);
        if (wr) check("R8 config wdata lanes", seen_wdata, order(wd, n, 0));
        else    check("R8 config rdata", rd, order(rsp_word, n, 0));
      end else begin
        exp_addr = (base + 32'(k)) & 32'h0000_FFFF;
        check("R4 io space", 32'(seen_space), 1);
        check("R4 io addr", seen_addr, exp_addr);
        if (wr) check("R7 io wdata lanes", seen_wdata, order(wd, n, 1));
        else    check("R7 io rdata", rd, order(rsp_word, n, 1));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready low after reset", 32'(cpu_req_ready), 0);
    check("R11 no request after reset", 32'(dn_req_valid), 0);
    run_and_check(4'h0, 3'd4, 1'b0, 0);              // R1 reset value 0
    run_and_check(4'h0, 3'd4, 1'b1, 32'hABCD_1237);  // R1 low bits kept
    run_and_check(4'h0, 3'd4, 1'b0, 0);
    run_and_check(4'h0, 3'd2, 1'b1, 32'h5555_5555);  // R2 rejected
    run_and_check(4'h0, 3'd4, 1'b0, 0);
    run_and_check(4'h7, 3'd1, 1'b0, 0);              // R3 cfg byte 3
    run_and_check(4'h4, 3'd4, 1'b1, 32'h1122_3344);  // R8
    run_and_check(4'h0, 3'd4, 1'b1, 32'h1234_FFFE);
    run_and_check(4'hB, 3'd1, 1'b0, 0);              // R4 wrap edge 0xFFFF
    run_and_check(4'h8, 3'd4, 1'b1, 32'h1122_3344);  // R7
    run_and_check(4'hA, 3'd2, 1'b0, 0);              // R7 half at +2
    run_and_check(4'h9, 3'd2, 1'b0, 0);              // R5 illegal
    run_and_check(4'h8, 3'd3, 1'b1, 32'h1);          // R5 size 3
    run_and_check(4'hA, 3'd4, 1'b0, 0);              // R5
    run_and_check(4'hC, 3'd1, 1'b0, 0);              // R6
    run_and_check(4'h2, 3'd1, 1'b0, 0);              // R6
    for (int t = 0; t < 400; t++) begin
      logic [3:0] o;
      logic [2:0] s;
      o = 4'($urandom_range(0, 15));
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                     : (($urandom_range(0, 1) == 1) ? 3'd1 : 3'd4);
      if ($urandom_range(0, 5) == 0) begin o = 4'h0; s = 3'd4; end
      run_and_check(o, s, 1'($urandom_range(0, 1)), $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule